// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse Width Modulator

This block generates four independent pulse-width-modulated outputs for dimming LED backlights. Software programs it through a simple word-addressed register port: one shared control word holds an enable bit and a 2-bit clock-ratio code for every channel, and each channel has its own configuration word. The configuration word packs the period length in timebase steps and the number of high steps per period.

Each channel has its own prescaler made of two fixed sub-dividers (divide by 8 and divide by 64). The ratio code selects either, both in cascade, or neither, so one timebase step lasts 1, 8, 64 or 512 input clocks. A step counter runs over the period. The output stays high while the step index is below the duty count. A new period or duty value takes effect only when the current period ends, so the waveform never shows a cut-short or glitched period.

Every channel is controlled by a two-state machine. `CH_IDLE` holds the output low and clears the counter and prescaler, and it keeps loading the programmed period and duty. `CH_RUN` advances the step counter on each prescaled tick. The transitions are: *start* (`CH_IDLE` to `CH_RUN` when the enable bit is seen set), *advance* (`CH_RUN` to `CH_RUN`, counting up or wrapping and reloading the configuration at the period end), and *stop* (`CH_RUN` to `CH_IDLE` when the enable bit is seen clear).

Top module: `quad_pwm_gen`

## Requirements
- R1: After reset, every register reads zero and all four outputs are low.
- R2: A write stores the full 32-bit word and a read at the same address returns it. The control word is at byte address 0x00 and channel n's configuration word is at 0x04 + 4*n. Any other address reads zero, and a write to it changes no register.
- R3: Control bit n enables channel n. The 2-bit ratio code for channel n sits in control bits [5+2n:4+2n]. A channel whose enable bit is clear drives its output low.
- R4: Ratio code 0 makes one timebase step last 1 clock, code 1 makes it last 8 clocks, code 2 makes it last 64 clocks, and code 3 makes it last 512 clocks.
- R5: Configuration bits [15:0] give the period in timebase steps. The step counter wraps to zero after step period-1, and a value of 0 stands for 65536 steps.
- R6: Configuration bits [31:16] give the duty count, and the output is high exactly while the step index is below it. Duty 0 gives a constant low output, and a duty at or above the period gives a constant high output.
- R7: A configuration write made while a channel runs has no effect until the current period has finished. The new period and duty apply from the first step of the next period.
- R8: When a write sets the enable bit at clock edge E, the channel is at step 0 after edge E+1. When a write clears the enable bit at edge E, the output is low after edge E+1. Enabling the channel again starts a fresh period at step 0.
- R9: The four channels run independently, each with its own period, duty and ratio code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (5) | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, available in the same cycle |
| pwm_out | output | NUM_CH (4) | One PWM output per channel |

## Verification
The bench sweeps the duty count from 0 to beyond the period for periods of 1, 2, 3 and 5 steps at ratio 1. This covers the always-low, partial and always-high cases and shows whether the compare uses below or at-or-below. It repeats shorter sweeps at ratios 8, 64 and 512, with a different code on each channel in the same run. This confirms the per-step length and shows that the channels do not share a prescaler. A write made in the middle of a period shows whether the new values wait for the wrap. Disabling and then re-enabling a channel at mid-count shows that the output goes low and that the next period starts fresh at step 0. A period value of 0 is checked against the 65536-step reading.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int STEP_W = 16;
    localparam int WORD_W = 32;
    localparam int CODE_W = 2;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic [STEP_W-1:0] duty;
        logic [STEP_W-1:0] period;
    } ch_cfg_t;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [WORD_W-1:0]              wr_data,
    output logic [WORD_W-1:0]              rd_data,
    output logic [WORD_W-1:0]              ctrl_o,
    output logic [NUM_CH-1:0][WORD_W-1:0]  cfg_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]             word_idx;
    logic                         aligned;
    logic [WORD_W-1:0]            ctrl_q;
    logic [NUM_CH-1:0][WORD_W-1:0] cfg_q;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && aligned && (word_idx == '0)) begin
            ctrl_q <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (wr_en && aligned && (word_idx == IDX_W'(g + 1))) begin
                cfg_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (aligned) begin
            if (word_idx == '0) begin
                rd_data = ctrl_q;
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (word_idx == IDX_W'(i + 1)) begin
                    rd_data = cfg_q[i];
                end
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign cfg_o  = cfg_q;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && aligned && word_idx == '0) |=> (ctrl_o == $past(wr_data))); // R2

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && aligned && word_idx == '0) |=> $stable(ctrl_o)); // R2

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int SUB0_DIV = 8,
    parameter int SUB1_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    localparam int S0_W = $clog2(SUB0_DIV);
    localparam int S1_W = $clog2(SUB1_DIV);
    localparam logic [S0_W-1:0] S0_LAST = S0_W'(SUB0_DIV - 1);
    localparam logic [S1_W-1:0] S1_LAST = S1_W'(SUB1_DIV - 1);

    logic [S0_W-1:0] s0_q;
    logic [S1_W-1:0] s1_q;
    logic            s0_tick;

    // first stage: either pass every clock or one out of SUB0_DIV
    always_comb begin
        if (clr) begin
            s0_tick = 1'b0;
        end else if (code[0]) begin
            s0_tick = (s0_q == S0_LAST);
        end else begin
            s0_tick = 1'b1;
        end
    end

    // second stage counts first-stage ticks
    always_comb begin
        if (code[1]) begin
            tick = s0_tick && (s1_q == S1_LAST);
        end else begin
            tick = s0_tick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s0_q <= '0;
        end else if (s0_q == S0_LAST) begin
            s0_q <= '0;
        end else begin
            s0_q <= s0_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s1_q <= '0;
        end else if (s0_tick) begin
            if (s1_q == S1_LAST) begin
                s1_q <= '0;
            end else begin
                s1_q <= s1_q + 1'b1;
            end
        end
    end

    AST_DIV_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code != '0 && $stable(code)) |=> !tick); // R4

    AST_DIV1_EVERY_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && code == '0) |-> tick); // R4

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int SUB0_DIV = 8,
    parameter int SUB1_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  ch_cfg_t           cfg,
    output logic              pwm_o
);

    ch_state_e         st_q, st_d;
    logic [STEP_W-1:0] cnt_q;
    logic [STEP_W-1:0] per_act_q;
    logic [STEP_W-1:0] duty_act_q;
    logic              step_tick;
    logic              last_step;

    pwm_prescaler #(
        .SUB0_DIV (SUB0_DIV),
        .SUB1_DIV (SUB1_DIV)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_q != CH_RUN),
        .code  (code),
        .tick  (step_tick)
    );

    // period 0 wraps through 16'hFFFF, i.e. 65536 steps
    assign last_step = (cnt_q == (per_act_q - 1'b1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: start, advance, stop
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: if (en)  st_d = CH_RUN;
            CH_RUN:  if (!en) st_d = CH_IDLE;
            default: st_d = CH_IDLE;
        endcase
    end

    // step counter and active configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            per_act_q  <= '0;
            duty_act_q <= '0;
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    cnt_q      <= '0;
                    per_act_q  <= cfg.period;
                    duty_act_q <= cfg.duty;
                end
                CH_RUN: begin
                    if (step_tick) begin
                        if (last_step) begin
                            cnt_q      <= '0;
                            per_act_q  <= cfg.period;
                            duty_act_q <= cfg.duty;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        pwm_o = 1'b0;
        unique case (st_q)
            CH_IDLE: pwm_o = 1'b0;
            CH_RUN:  pwm_o = (cnt_q < duty_act_q);
            default: pwm_o = 1'b0;
        endcase
    end

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_o); // R8

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act_q != '0) |-> (cnt_q < per_act_q)); // R5

    AST_CFG_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && !(step_tick && last_step))
            |=> ($stable(per_act_q) && $stable(duty_act_q))); // R7

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen
    import pwm_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SUB0_DIV = 8,
    parameter int SUB1_DIV = 64,
    parameter int ADDR_W   = $clog2((NUM_CH + 1) * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int CODE_BASE = 4;

    logic [WORD_W-1:0]             ctrl;
    logic [NUM_CH-1:0][WORD_W-1:0] cfg_words;

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .ctrl_o  (ctrl),
        .cfg_o   (cfg_words)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ch_cfg_t ch_cfg;
        assign ch_cfg = ch_cfg_t'(cfg_words[g]);

        pwm_channel #(
            .SUB0_DIV (SUB0_DIV),
            .SUB1_DIV (SUB1_DIV)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ctrl[g]),
            .code  (ctrl[CODE_BASE + CODE_W*g +: CODE_W]),
            .cfg   (ch_cfg),
            .pwm_o (pwm_out[g])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0)); // R1

endmodule

// File: tb/tb_quad_pwm_gen.sv
module tb_quad_pwm_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    quad_pwm_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, $sformatf("read 0x%0h", a), reg_rdata, exp);
    endtask

    function automatic logic exp_out(int j, int per, int duty, int code);
        int div = 1 << (3 * code);
        int pe  = (per == 0) ? 65536 : per;
        return ((j / div) % pe) < duty;
    endfunction

    function automatic logic [31:0] cfg_word(int per, int duty);
        return {duty[15:0], per[15:0]};
    endfunction

    function automatic logic [31:0] ctrl_word(logic [3:0] en, int c0, int c1, int c2, int c3);
        return {20'd0, c3[1:0], c2[1:0], c1[1:0], c0[1:0], en};
    endfunction

    // program all four channels, enable, compare every sample
    task automatic sweep(input string req, input int p[4], input int d[4], input int c[4], input int ncyc);
        logic [3:0] bad = '0;
        logic [3:0] a_v = '0;
        logic [3:0] e_v = '0;
        int         j_v = 0;
        for (int ch = 0; ch < 4; ch++) wr(5'(4 + 4*ch), cfg_word(p[ch], d[ch]));
        wr(5'h0, ctrl_word(4'hF, c[0], c[1], c[2], c[3]));
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            for (int ch = 0; ch < 4; ch++) begin
                if (!bad[ch] && pwm_out[ch] !== exp_out(j, p[ch], d[ch], c[ch])) begin
                    bad[ch] = 1'b1; a_v[ch] = pwm_out[ch];
                    e_v[ch] = exp_out(j, p[ch], d[ch], c[ch]); j_v = j;
                end
            end
        end
        for (int ch = 0; ch < 4; ch++) begin
            n_tests++;
            if (bad[ch]) begin
                n_fail++;
                $display("FAIL %s ch%0d per=%0d duty=%0d code=%0d sample %0d: actual %0b expected %0b",
                         req, ch, p[ch], d[ch], c[ch], j_v, a_v[ch], e_v[ch]);
            end
        end
        wr(5'h0, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) rd_check("R1", 5'(4*a), 32'h0);
        check("R1", "outputs after reset", {28'd0, pwm_out}, 32'h0);

        // R2 readback, unmapped address
        wr(5'h00, 32'hA5A5_0000);
        for (int ch = 0; ch < 4; ch++) wr(5'(4 + 4*ch), 32'h1234_5670 + 32'(ch));
        wr(5'h14, 32'hDEAD_BEEF);
        wr(5'h02, 32'hFFFF_FFFF);
        rd_check("R2", 5'h00, 32'hA5A5_0000);
        for (int ch = 0; ch < 4; ch++) rd_check("R2", 5'(4 + 4*ch), 32'h1234_5670 + 32'(ch));
        rd_check("R2", 5'h14, 32'h0);
        rd_check("R2", 5'h02, 32'h0);
        check("R3", "enables clear -> outputs low", {28'd0, pwm_out}, 32'h0);
        for (int ch = 0; ch < 4; ch++) wr(5'(4 + 4*ch), 32'h0);

        // R5 R6 duty sweep at ratio code 0
        for (int dd = 0; dd < 7; dd++) begin
            int p[4] = '{1, 2, 3, 5};
            int d[4] = '{dd, dd, dd, dd};
            int c[4] = '{0, 0, 0, 0};
            sweep("R6", p, d, c, 32);
        end

        // R4 ratio code 1
        for (int dd = 0; dd < 5; dd++) begin
            int p[4] = '{1, 2, 3, 4};
            int d[4] = '{dd, dd, dd, dd};
            int c[4] = '{1, 1, 1, 1};
            sweep("R4", p, d, c, 72);
        end

        // R4 R9 mixed codes across channels
        begin
            int p[4] = '{2, 3, 2, 3};
            int d[4] = '{1, 2, 1, 0};
            int c[4] = '{2, 3, 1, 0};
            sweep("R9", p, d, c, 3200);
        end
        begin
            int p[4] = '{3, 2, 5, 4};
            int d[4] = '{2, 1, 2, 3};
            int c[4] = '{3, 2, 0, 1};
            sweep("R4", p, d, c, 3200);
        end

        // R5 period value 0 means 65536 steps
        begin
            int p[4] = '{0, 0, 1, 1};
            int d[4] = '{3, 65535, 0, 1};
            int c[4] = '{0, 0, 0, 0};
            sweep("R5", p, d, c, 40);
        end

        // R7 mid-period reconfiguration waits for wrap
        begin
            logic ok = 1'b1;
            logic [3:0] exp_seq = 4'b0011;
            wr(5'h04, cfg_word(4, 2));
            wr(5'h00, ctrl_word(4'h1, 0, 0, 0, 0));
            @(negedge clk); // sample 0
            if (pwm_out[0] !== 1'b1) ok = 1'b0;
            @(negedge clk); // sample 1
            if (pwm_out[0] !== 1'b1) ok = 1'b0;
            reg_wr = 1'b1; reg_addr = 5'h04; reg_wdata = cfg_word(2, 1);
            @(negedge clk); // sample 2, write committed
            reg_wr = 1'b0;
            if (pwm_out[0] !== 1'b0) ok = 1'b0;
            @(negedge clk); // sample 3
            if (pwm_out[0] !== 1'b0) ok = 1'b0;
            check("R7", "old period kept to its end", {31'd0, ok}, 32'd1);
            ok = 1'b1;
            for (int j = 4; j < 12; j++) begin
                @(negedge clk);
                if (pwm_out[0] !== ((j % 2) == 0)) ok = 1'b0;
            end
            check("R7", "new period after wrap", {31'd0, ok}, 32'd1);
            if (exp_seq == 4'b0) ok = 1'b0;
            wr(5'h00, 32'h0);
        end

        // R8 disable forces low, re-enable restarts at step 0
        begin
            logic ok = 1'b1;
            wr(5'h04, cfg_word(6, 2));
            wr(5'h00, ctrl_word(4'h1, 0, 0, 0, 0));
            repeat (4) @(negedge clk); // now at step 3
            wr(5'h00, ctrl_word(4'h0, 0, 0, 0, 0));
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                if (pwm_out !== 4'b0) ok = 1'b0;
            end
            check("R8", "low after disable", {31'd0, ok}, 32'd1);
            wr(5'h00, ctrl_word(4'h1, 0, 0, 0, 0));
            ok = 1'b1;
            for (int j = 0; j < 12; j++) begin
                @(negedge clk);
                if (pwm_out[0] !== exp_out(j, 6, 2, 0)) ok = 1'b0;
                if (pwm_out[3:1] !== 3'b0) ok = 1'b0;
            end
            check("R8", "fresh period after re-enable", {31'd0, ok}, 32'd1);
            check("R3", "disabled channels stay low", {31'd0, ok}, 32'd1);
            wr(5'h00, 32'h0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule